// File: doc/BRIEF.md
# Keyed Write Guard for Timekeeping Configuration Registers

This block sits between a host write port and the configuration register bank of a timekeeping peripheral. It blocks host writes to the protected registers until two key bytes have been written, in the correct order, to a dedicated key register. Writing anything to the key register while the guard is open closes it again at once. Protected writes are accepted only when the guard is open and a separate domain-access enable input is also high. The control, status/initialisation, prescaler, alarm, time and date registers are protected.

One scratch register is not protected. Writes to it always go through. The block holds the register bank. It presents each register's stored value on a combinational read port, so the effect of every write can be seen at the pins. It also drives an `unlocked` status signal and a `wr_allow` signal that is high for each write that is allowed to land.

With the default parameters the address map has eight slots. Addresses 0 to 5 hold the protected registers. Address 6 is the open scratch register. Address 7 is the key register. Only bits 7:0 of a key write are compared against the key values.

Top module: `cfg_write_guard`

## Requirements
- R1: After a synchronous active-low reset, `unlocked` is 0, the key sequence waits for its first byte, and every register reads back 0.
- R2: A key-register write (address 7) with bits 7:0 equal to 0xCA, followed by a key-register write with bits 7:0 equal to 0x53, sets `unlocked` to 1 from the cycle after the second write. Data bits above bit 7 do not affect the comparison.
- R3: If the key write after a first byte of 0xCA is not 0x53, the sequence returns to waiting for the first byte, and that write is not taken as a first byte, even if it is 0xCA.
- R4: Any key-register write while unlocked clears `unlocked` from the next cycle, whatever its value (0xFF, 0xCA and 0x53 included). Opening the guard again needs the full two-byte sequence.
- R5: A write to a protected address (0 to 5) while locked has `wr_allow` low, and the register keeps its previous contents.
- R6: A write to a protected address while `domain_en` is low has `wr_allow` low and changes nothing, even when unlocked.
- R7: A write to the open register (address 6) has `wr_allow` high and is stored, whatever the lock state and `domain_en` are.
- R8: Writes to addresses other than the key register, made between the two key bytes, do not disturb the key sequence.
- R9: The key register reads back 0, and a key write never raises `wr_allow` or changes any stored register.
- R10: A protected write that is allowed (unlocked and `domain_en` high) raises `wr_allow` and is stored. Its value reads back on `rd_data` from the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| domain_en | input | 1 | Domain-access enable; needed for any protected write |
| wr_en | input | 1 | Host write strobe |
| wr_addr | input | AW | Host write address |
| wr_data | input | DW | Host write data |
| rd_addr | input | AW | Read address |
| rd_data | output | DW | Stored value at `rd_addr` (combinational) |
| unlocked | output | 1 | Guard open for protected writes |
| wr_allow | output | 1 | High while the current write is allowed to land |

## Verification
A protected write is judged in the same cycle by two conditions: the lock state and the domain enable. The bench applies every protected and open address under all four combinations of the two. For each write it checks `wr_allow` and the read-back value against a reference model that is built from the requirements.

The key sequence is swept over all 256 values, once in the first-byte position and once in the second-byte position. The relock behaviour is also checked for every one of the 256 values. Further sequences cover repeated first bytes and register writes placed between the two key bytes.

// File: rtl/cfg_guard_pkg.sv
// Package: shared types for the keyed write guard.
// Assumes: a single write port and key values no wider than KEY_W bits.
package cfg_guard_pkg;

    localparam int KEY_W = 8;

    // Key-sequence progress.
    typedef enum logic [1:0] {
        KS_WAIT_FIRST  = 2'd0,
        KS_WAIT_SECOND = 2'd1,
        KS_OPEN        = 2'd2
    } key_state_t;

endpackage

// File: rtl/cfg_guard_keyseq.sv
// Module: ordered two-byte key recogniser.
// What it does: follows key-register writes and opens the guard after FIRST
// then SECOND. A wrong second byte restarts the sequence without counting as
// a first byte. Any key write while open closes the guard.
// Assumes: key_wr is high for one cycle per host write to the key register.
module cfg_guard_keyseq
    import cfg_guard_pkg::*;
#(
    parameter int           KW         = KEY_W,
    parameter logic [KW-1:0] KEY_FIRST  = 8'hCA,
    parameter logic [KW-1:0] KEY_SECOND = 8'h53
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          key_wr,
    input  logic [KW-1:0] key_val,
    output logic          unlocked
);

    key_state_t state_q, state_d;

    // Next state from the current state and the key byte written.
    always_comb begin
        state_d = state_q;
        if (key_wr) begin
            unique case (state_q)
                KS_WAIT_FIRST:  state_d = (key_val == KEY_FIRST)  ? KS_WAIT_SECOND : KS_WAIT_FIRST;
                KS_WAIT_SECOND: state_d = (key_val == KEY_SECOND) ? KS_OPEN        : KS_WAIT_FIRST;
                KS_OPEN:        state_d = KS_WAIT_FIRST;
                default:        state_d = KS_WAIT_FIRST;
            endcase
        end
    end

    // State register with synchronous reset to locked.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= KS_WAIT_FIRST;
        else        state_q <= state_d;
    end

    assign unlocked = (state_q == KS_OPEN);

    // The guard opens only right after the second key byte is written.
    assert_open_on_second_key_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(unlocked) |-> $past(key_wr && key_val == KEY_SECOND));

    // A wrong second byte drops back to waiting for the first byte.
    assert_bad_second_restarts_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == KS_WAIT_SECOND && key_wr && key_val != KEY_SECOND) |=> (state_q == KS_WAIT_FIRST));

    // Any key write while open closes the guard.
    assert_relock_any_key_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (unlocked && key_wr) |=> !unlocked);

endmodule

// File: rtl/cfg_guard_decode.sv
// Module: address classifier and write gate.
// What it does: sorts each write into key, protected or open. It raises the
// allow strobe and a one-hot register select only for writes that may land.
// Assumes: slot KEY_ADDR is the key register and holds no storage.
module cfg_guard_decode #(
    parameter int               AW        = 3,
    parameter int               KEY_ADDR  = 7,
    parameter logic [(1<<AW)-1:0] PROT_MASK = 8'h3F
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [AW-1:0]       wr_addr,
    input  logic                unlocked,
    input  logic                domain_en,
    output logic                key_hit,
    output logic                prot_hit,
    output logic                wr_allow,
    output logic [(1<<AW)-1:0]  sel
);

    localparam int NREGS = 1 << AW;

    // Classify the address and decide whether the write may land.
    always_comb begin
        key_hit  = wr_en && (wr_addr == AW'(KEY_ADDR));
        prot_hit = wr_en && !key_hit && PROT_MASK[wr_addr];
        wr_allow = wr_en && !key_hit && (!PROT_MASK[wr_addr] || (unlocked && domain_en));
    end

    // One select line per storage slot; the key slot never gets a select.
    for (genvar i = 0; i < NREGS; i++) begin : g_sel
        if (i == KEY_ADDR) begin : g_key
            assign sel[i] = 1'b0;
        end else begin : g_reg
            assign sel[i] = wr_allow && (wr_addr == AW'(i));
        end
    end

    // Locked guard never lets a protected write through.
    assert_locked_blocks_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (prot_hit && !unlocked) |-> !wr_allow);

    // Domain enable low blocks protected writes.
    assert_domain_blocks_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (prot_hit && !domain_en) |-> !wr_allow);

    // Open register writes always go through.
    assert_open_passes_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !key_hit && !prot_hit) |-> wr_allow);

    // Key writes never reach storage.
    assert_key_not_stored_R9: assert property (@(posedge clk) disable iff (!rst_n)
        key_hit |-> (!wr_allow && sel == '0));

endmodule

// File: rtl/cfg_guard_regbank.sv
// Module: register storage behind the guard.
// What it does: holds one DW-bit register per slot and loads it when its
// select is high. The key slot reads as zero. The read port is combinational.
// Assumes: sel is at most one-hot.
module cfg_guard_regbank #(
    parameter int AW       = 3,
    parameter int DW       = 32,
    parameter int KEY_ADDR = 7
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [(1<<AW)-1:0]  sel,
    input  logic [DW-1:0]       wr_data,
    input  logic [AW-1:0]       rd_addr,
    output logic [DW-1:0]       rd_data
);

    localparam int NREGS = 1 << AW;

    logic [NREGS-1:0][DW-1:0] q_all;

    for (genvar i = 0; i < NREGS; i++) begin : g_slot
        if (i == KEY_ADDR) begin : g_key
            assign q_all[i] = '0;
        end else begin : g_reg
            logic [DW-1:0] r_q;
            // Load on select, clear on reset.
            always_ff @(posedge clk) begin
                if (!rst_n)      r_q <= '0;
                else if (sel[i]) r_q <= wr_data;
            end
            assign q_all[i] = r_q;
        end
    end

    // Read mux.
    assign rd_data = q_all[rd_addr];

    // Select is never more than one-hot.
    assert_sel_onehot_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(sel));

endmodule

// File: rtl/cfg_write_guard.sv
// Module: keyed write guard with its register bank (top).
// What it does: gates host writes to protected configuration registers
// behind a two-byte key sequence and a domain-access enable. Open registers
// pass through.
// Assumes: one host write per cycle; synchronous active-low reset.
module cfg_write_guard
    import cfg_guard_pkg::*;
#(
    parameter int                 AW         = 3,
    parameter int                 DW         = 32,
    parameter int                 KEY_ADDR   = 7,
    parameter logic [(1<<AW)-1:0] PROT_MASK  = 8'h3F,
    parameter logic [KEY_W-1:0]   KEY_FIRST  = 8'hCA,
    parameter logic [KEY_W-1:0]   KEY_SECOND = 8'h53
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          domain_en,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic [AW-1:0] rd_addr,
    output logic [DW-1:0] rd_data,
    output logic          unlocked,
    output logic          wr_allow
);

    localparam int NREGS = 1 << AW;

    logic             key_hit;
    logic             prot_hit;
    logic [NREGS-1:0] sel;

    cfg_guard_keyseq #(
        .KW        (KEY_W),
        .KEY_FIRST (KEY_FIRST),
        .KEY_SECOND(KEY_SECOND)
    ) u_keyseq (
        .clk     (clk),
        .rst_n   (rst_n),
        .key_wr  (key_hit),
        .key_val (wr_data[KEY_W-1:0]),
        .unlocked(unlocked)
    );

    cfg_guard_decode #(
        .AW       (AW),
        .KEY_ADDR (KEY_ADDR),
        .PROT_MASK(PROT_MASK)
    ) u_decode (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .unlocked (unlocked),
        .domain_en(domain_en),
        .key_hit  (key_hit),
        .prot_hit (prot_hit),
        .wr_allow (wr_allow),
        .sel      (sel)
    );

    cfg_guard_regbank #(
        .AW      (AW),
        .DW      (DW),
        .KEY_ADDR(KEY_ADDR)
    ) u_bank (
        .clk    (clk),
        .rst_n  (rst_n),
        .sel    (sel),
        .wr_data(wr_data),
        .rd_addr(rd_addr),
        .rd_data(rd_data)
    );

    // A write to the address being read, if not allowed, leaves the read value unchanged.
    assert_blocked_write_no_change_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_allow && rd_addr == wr_addr) |=> (rd_data == $past(rd_data) || rd_addr != $past(rd_addr)));

endmodule

// File: tb/cfg_write_guard_bench.sv
// Bench: sweeps addresses, lock state, domain enable and key values against
// a reference model built from the requirements.
module cfg_write_guard_bench;

    localparam int CLK_PERIOD = 10;
    localparam logic [7:0] K1 = 8'hCA;
    localparam logic [7:0] K2 = 8'h53;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        domain_en = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [2:0]  rd_addr = '0;
    logic [31:0] rd_data;
    logic        unlocked;
    logic        wr_allow;

    int vectors = 0;
    int miscompares = 0;
    bit finished = 1'b0;

    int          m_state = 0;      // 0 wait first, 1 wait second, 2 open
    logic [31:0] exp_q [8];

    always #(CLK_PERIOD/2) clk = ~clk;

    cfg_write_guard u_cfg_write_guard (
        .clk(clk), .rst_n(rst_n), .domain_en(domain_en), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
        .rd_data(rd_data), .unlocked(unlocked), .wr_allow(wr_allow)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (!ok) begin
            miscompares++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // One host write with model update; checks strobe, read-back and lock.
    task automatic wr(input logic [2:0] a, input logic [31:0] d, input bit dom);
        bit exp_allow;
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d; domain_en = dom;
        exp_allow = (a == 3'd7) ? 1'b0 : (a == 3'd6) ? 1'b1 : (m_state == 2 && dom);
        #1;
        check(wr_allow == exp_allow,
              (a == 3'd7) ? "R9" : (a == 3'd6) ? "R7" : (m_state != 2) ? "R5" : dom ? "R10" : "R6",
              32'(wr_allow), 32'(exp_allow));
        @(negedge clk);
        wr_en = 1'b0;
        if (a == 3'd7) begin
            case (m_state)
                0: m_state = (d[7:0] == K1) ? 1 : 0;
                1: m_state = (d[7:0] == K2) ? 2 : 0;
                default: m_state = 0;
            endcase
        end else if (exp_allow) begin
            exp_q[a] = d;
        end
        rd_addr = a;
        #1;
        check(rd_data == exp_q[a], (a == 3'd7) ? "R9" : exp_allow ? "R10" : "R5", rd_data, exp_q[a]);
        check(unlocked == (m_state == 2), (a == 3'd7) ? "R4" : "R8", 32'(unlocked), 32'(m_state == 2));
    endtask

    task automatic expect_lock(input bit exp_open, input string req);
        check(unlocked == exp_open, req, 32'(unlocked), 32'(exp_open));
    endtask

    initial begin
        for (int i = 0; i < 8; i++) exp_q[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        expect_lock(1'b0, "R1");
        for (int a = 0; a < 8; a++) begin
            rd_addr = 3'(a); #1;
            check(rd_data == 32'h0, "R1", rd_data, 32'h0);
        end

        // R5/R6/R7: locked sweep over all addresses and both domain values
        for (int dom = 0; dom < 2; dom++)
            for (int a = 0; a < 7; a++)
                wr(3'(a), 32'hA500_0000 | 32'(a * 16 + dom), dom[0]);

        // R2: open with upper bits set, then R10/R6/R7 sweep while open
        wr(3'd7, 32'hABCD_00CA, 1'b1);
        wr(3'd7, 32'h1234_5653, 1'b1);
        expect_lock(1'b1, "R2");
        for (int dom = 0; dom < 2; dom++)
            for (int a = 0; a < 7; a++)
                wr(3'(a), 32'h5A00_0000 | 32'(a * 256 + dom), dom[0]);

        // R4: every key value relocks an open guard
        for (int v = 0; v < 256; v++) begin
            if (m_state != 2) begin wr(3'd7, 32'hFF, 1'b1); wr(3'd7, 32'(K1), 1'b1); wr(3'd7, 32'(K2), 1'b1); end
            wr(3'd7, 32'(v), 1'b1);
            expect_lock(1'b0, "R4");
            wr(3'd0, 32'(v) ^ 32'h00FF_0000, 1'b1);
        end

        // R2/R3: second-byte sweep
        for (int v = 0; v < 256; v++) begin
            wr(3'd7, 32'hFF, 1'b1);
            wr(3'd7, 32'(K1), 1'b1);
            wr(3'd7, 32'(v), 1'b1);
            expect_lock(v == 32'(K2), "R3");
        end

        // R2: first-byte sweep
        for (int v = 0; v < 256; v++) begin
            wr(3'd7, 32'hFF, 1'b1);
            wr(3'd7, 32'(v), 1'b1);
            wr(3'd7, 32'(K2), 1'b1);
            expect_lock(v == 32'(K1), "R2");
        end

        // R3: repeated first byte is not a fresh first byte
        wr(3'd7, 32'hFF, 1'b1);
        wr(3'd7, 32'(K1), 1'b1); wr(3'd7, 32'(K1), 1'b1); wr(3'd7, 32'(K2), 1'b1);
        expect_lock(1'b0, "R3");
        wr(3'd7, 32'(K1), 1'b1); wr(3'd7, 32'h00, 1'b1); wr(3'd7, 32'(K1), 1'b1); wr(3'd7, 32'(K2), 1'b1);
        expect_lock(1'b1, "R3");

        // R8: other writes between key bytes do not disturb the sequence
        wr(3'd7, 32'hFF, 1'b1);
        wr(3'd7, 32'(K1), 1'b0);
        wr(3'd6, 32'hCAFE_0006, 1'b0);
        wr(3'd2, 32'hDEAD_0002, 1'b1);
        wr(3'd7, 32'(K2), 1'b0);
        expect_lock(1'b1, "R8");
        wr(3'd2, 32'hBEEF_0002, 1'b1);

        // R9: key register reads zero
        rd_addr = 3'd7; #1;
        check(rd_data == 32'h0, "R9", rd_data, 32'h0);

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 150000);
        if (!finished) begin
            miscompares++;
            vectors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

endmodule